// File: doc/BRIEF.md
# Aperture Page Translation Cache

This block translates page numbers inside a graphics aperture into physical page numbers. Three requesters share it: the host CPU, the graphics-port master and the PCI master. It holds a small, fully associative set of translations and has no second level behind it. On a hit the physical address comes back combinationally, in the same cycle as the request. On a miss the block asks an external page-table walker for the entry and writes the returned translation into the array. While that fill is outstanding the request port stalls.

Each requester has its own enable input. A requester whose enable is low bypasses the array entirely, and its address is returned untouched. A one-cycle flush invalidates the whole array.

Top module: `aperture_xlat_cache`

## Requirements
- R1: After reset every entry is invalid, `fill_req_o` is low, and the first translated lookup of any page misses.
- R2: A request that is not translated completes in the cycle it is presented, with `rsp_addr_o` equal to `req_addr_i`, and it raises no fill. A request is not translated when its source's enable is low, or when its source code is 3. The source codes are 0 host, 1 graphics-port master, 2 PCI master and 3 reserved.
- R3: A translated request that hits completes in the same cycle. `rsp_addr_o` then holds the stored physical page in bits 31:12.
- R4: A translated miss drops `req_ready_o`. From the next cycle `fill_req_o` stays high, with `fill_vpn_o` equal to request address bits 31:12, until a cycle in which `fill_valid_i` is high.
- R5: While a fill is outstanding, `req_ready_o` stays low for every source, including bypassed ones. The requester may replace an unaccepted request.
- R6: A fill goes into the lowest-indexed invalid entry. While any entry is invalid, no valid translation is evicted.
- R7: When all 16 entries are valid, a fill replaces the least recently used entry. Both hits and fills count as uses.
- R8: A miss does not change the recency order. Only the completed fill does.
- R9: `flush_i` invalidates every entry at the next clock edge and restores the initial order. If a fill arrives in the same cycle as a flush, the fill is dropped and the request misses again.
- R10: The three enables act independently, and all enabled sources share one set of cached translations.
- R11: `fill_valid_i` has no effect when no fill is outstanding.
- R12: Address bits 11:0 pass from request to response unchanged in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all entries |
| host_en_i | input | 1 | Translate host requests |
| agp_en_i | input | 1 | Translate graphics-port master requests |
| pci_en_i | input | 1 | Translate PCI master requests |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted this cycle |
| req_src_i | input | 2 | Requester code |
| req_addr_i | input | 32 | Aperture address |
| rsp_valid_o | output | 1 | Response valid (same cycle as acceptance) |
| rsp_addr_o | output | 32 | Translated or passed-through address |
| fill_req_o | output | 1 | Fill outstanding |
| fill_vpn_o | output | 20 | Page to fetch |
| fill_valid_i | input | 1 | Walker returns an entry |
| fill_ppn_i | input | 20 | Physical page returned |

## Verification
The hardest state to reach is a full array with a known recency order, followed by a miss that must evict exactly one chosen entry. The stimulus first fills all sixteen entries, then touches them in a deliberate order, and then follows each eviction with lookups whose hit or miss exposes which entry was lost. A reference recency list in the bench predicts every hit and miss, and that prediction carries through a long randomized phase over more pages than the array holds. A second awkward case is switching a stalled request to a bypassed source while the fill is in flight; the bench does this once the walker has seen the fill request.

// File: rtl/axc_pkg.sv
package axc_pkg;
  typedef enum logic [1:0] {
    SRC_HOST = 2'd0,
    SRC_AGP  = 2'd1,
    SRC_PCI  = 2'd2,
    SRC_RSVD = 2'd3
  } req_src_e;
endpackage

// File: rtl/axc_tag_array.sv
module axc_tag_array #(
  parameter int N     = 16,
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [VPN_W-1:0] wr_vpn_i,
  input  logic [PPN_W-1:0] wr_ppn_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] hit_idx_o,
  output logic [PPN_W-1:0] hit_ppn_o,
  output logic [N-1:0]     valid_o
);
  logic             vld_q [N];
  logic [VPN_W-1:0] tag_q [N];
  logic [PPN_W-1:0] ppn_q [N];
  logic [N-1:0]     match;

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
        tag_q[g] <= '0;
        ppn_q[g] <= '0;
      end else if (flush_i) begin
        vld_q[g] <= 1'b0;
      end else if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
        vld_q[g] <= 1'b1;
        tag_q[g] <= wr_vpn_i;
        ppn_q[g] <= wr_ppn_i;
      end
    end
    assign match[g]   = vld_q[g] && (tag_q[g] == lk_vpn_i);
    assign valid_o[g] = vld_q[g];
  end

  always_comb begin
    hit_idx_o = '0;
    hit_ppn_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_idx_o = IDX_W'(i);
        hit_ppn_o = ppn_q[i];
      end
    end
  end
  assign hit_o = |match;

  // R9
  flush_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_o == '0));
  // R6
  match_unique_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));
endmodule

// File: rtl/axc_lru.sv
module axc_lru #(
  parameter int N = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  input  logic [N-1:0]     valid_i,
  output logic [IDX_W-1:0] victim_o
);
  logic [IDX_W-1:0] age_q [N];
  logic [N-1:0]     is_old;
  logic             has_free;
  logic [IDX_W-1:0] free_idx, old_idx;

  // age 0 = most recent; ages always form a permutation
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) age_q[i] <= IDX_W'(i);
    end else if (flush_i) begin
      for (int i = 0; i < N; i++) age_q[i] <= IDX_W'(i);
    end else if (touch_i) begin
      for (int i = 0; i < N; i++) begin
        if (IDX_W'(i) == touch_idx_i) age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx_i]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    has_free = 1'b0;
    free_idx = '0;
    old_idx  = '0;
    is_old   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        has_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
    for (int i = 0; i < N; i++) begin
      if (age_q[i] == IDX_W'(N - 1)) begin
        is_old[i] = 1'b1;
        old_idx   = IDX_W'(i);
      end
    end
  end
  assign victim_o = has_free ? free_idx : old_idx;

  // R7
  lru_unique_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(is_old) == 1);
endmodule

// File: rtl/aperture_xlat_cache.sv
module aperture_xlat_cache #(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 12,
  parameter int ENTRIES = 16,
  localparam int PG_W  = ADDR_W - OFF_W,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              host_en_i,
  input  logic              agp_en_i,
  input  logic              pci_en_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_src_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              rsp_valid_o,
  output logic [ADDR_W-1:0] rsp_addr_o,
  output logic              fill_req_o,
  output logic [PG_W-1:0]   fill_vpn_o,
  input  logic              fill_valid_i,
  input  logic [PG_W-1:0]   fill_ppn_i
);
  import axc_pkg::*;

  logic              xlat_en, hit, pend_q, miss_start, fill_take, wr_en, touch;
  logic [PG_W-1:0]   pend_vpn_q, hit_ppn, lk_vpn;
  logic [IDX_W-1:0]  hit_idx, victim, touch_idx;
  logic [ENTRIES-1:0] valid;

  always_comb begin
    unique case (req_src_e'(req_src_i))
      SRC_HOST: xlat_en = host_en_i;
      SRC_AGP:  xlat_en = agp_en_i;
      SRC_PCI:  xlat_en = pci_en_i;
      default:  xlat_en = 1'b0;
    endcase
  end

  assign lk_vpn      = req_addr_i[ADDR_W-1:OFF_W];
  assign req_ready_o = !pend_q && (!xlat_en || hit);
  assign rsp_valid_o = req_valid_i && req_ready_o;
  assign rsp_addr_o  = xlat_en ? {hit_ppn, req_addr_i[OFF_W-1:0]} : req_addr_i;

  assign miss_start = req_valid_i && xlat_en && !hit && !pend_q;
  assign fill_take  = pend_q && fill_valid_i;
  assign wr_en      = fill_take && !flush_i;
  assign touch      = wr_en || (rsp_valid_o && xlat_en);
  assign touch_idx  = wr_en ? victim : hit_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      pend_vpn_q <= '0;
    end else if (miss_start) begin
      pend_q     <= 1'b1;
      pend_vpn_q <= lk_vpn;
    end else if (fill_take) begin
      pend_q     <= 1'b0;
    end
  end
  assign fill_req_o = pend_q;
  assign fill_vpn_o = pend_vpn_q;

  axc_tag_array #(.N(ENTRIES), .VPN_W(PG_W), .PPN_W(PG_W)) u_tags (
    .clk_i, .rst_ni, .flush_i,
    .wr_en_i  (wr_en),
    .wr_idx_i (victim),
    .wr_vpn_i (pend_vpn_q),
    .wr_ppn_i (fill_ppn_i),
    .lk_vpn_i (lk_vpn),
    .hit_o    (hit),
    .hit_idx_o(hit_idx),
    .hit_ppn_o(hit_ppn),
    .valid_o  (valid)
  );

  axc_lru #(.N(ENTRIES)) u_lru (
    .clk_i, .rst_ni, .flush_i,
    .touch_i    (touch),
    .touch_idx_i(touch_idx),
    .valid_i    (valid),
    .victim_o   (victim)
  );

  // R4
  fill_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_o && !fill_valid_i) |=> (fill_req_o && $stable(fill_vpn_o)));
  // R5
  stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_o |-> !req_ready_o);
  // R11
  stray_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !fill_req_o && !flush_i && !(req_valid_i && req_ready_o)) |=> $stable(valid));
  // R12
  offset_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_addr_o[OFF_W-1:0] == req_addr_i[OFF_W-1:0]));
endmodule

// File: tb/sim_aperture_xlat_cache.sv
module sim_aperture_xlat_cache;
  logic clk = 1'b0, rst_ni = 1'b0, flush_i = 1'b0;
  logic host_en = 1'b1, agp_en = 1'b1, pci_en = 1'b0;
  logic req_valid = 1'b0, fill_valid = 1'b0;
  logic [1:0]  req_src = 2'd0;
  logic [31:0] req_addr = '0;
  logic [19:0] fill_ppn = '0;
  logic req_ready, rsp_valid, fill_req;
  logic [31:0] rsp_addr;
  logic [19:0] fill_vpn;

  int total = 0, bad = 0, fill_cnt = 0;
  logic [31:0] exp_q[$];
  logic [19:0] lru_q[$];
  logic [19:0] exp_fill_vpn;

  always #10 clk = ~clk;

  aperture_xlat_cache u0 (
    .clk_i(clk), .rst_ni, .flush_i,
    .host_en_i(host_en), .agp_en_i(agp_en), .pci_en_i(pci_en),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_src_i(req_src),
    .req_addr_i(req_addr), .rsp_valid_o(rsp_valid), .rsp_addr_o(rsp_addr),
    .fill_req_o(fill_req), .fill_vpn_o(fill_vpn),
    .fill_valid_i(fill_valid), .fill_ppn_i(fill_ppn)
  );

  function automatic logic [19:0] ppn_of(logic [19:0] v);
    return v * 20'd7 + 20'h003A5;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  function automatic bit en_of(logic [1:0] s);
    case (s)
      2'd0: return host_en;
      2'd1: return agp_en;
      2'd2: return pci_en;
      default: return 1'b0;
    endcase
  endfunction

  // reference recency list, most recent at the back; returns 1 on miss
  function automatic bit model_use(logic [19:0] v);
    for (int i = 0; i < lru_q.size(); i++) begin
      if (lru_q[i] == v) begin
        lru_q.delete(i);
        lru_q.push_back(v);
        return 1'b0;
      end
    end
    if (lru_q.size() == 16) lru_q.delete(0);
    lru_q.push_back(v);
    return 1'b1;
  endfunction

  // monitor: pops expected results as responses appear
  initial forever begin
    @(negedge clk);
    if (rst_ni && rsp_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R2/R3 unexpected response", rsp_addr, 32'h0);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(rsp_addr == e, "R3/R12 response address", rsp_addr, e);
      end
    end
  end

  // walker model
  initial forever begin
    @(negedge clk);
    if (rst_ni && fill_req) begin
      chk(fill_vpn == exp_fill_vpn, "R4 fill page", {12'h0, fill_vpn}, {12'h0, exp_fill_vpn});
      repeat (3) begin
        @(negedge clk);
        chk(fill_req && !req_ready, "R5 stall while pending", {30'h0, fill_req, req_ready}, 32'h2);
      end
      @(posedge clk); #1;
      fill_valid = 1'b1;
      fill_ppn   = ppn_of(fill_vpn);
      fill_cnt++;
      @(posedge clk); #1;
      fill_valid = 1'b0;
    end
  end

  task automatic lookup(logic [1:0] src, logic [19:0] vpn, logic [11:0] off);
    bit xl, miss;
    int f0;
    xl = en_of(src);
    miss = xl ? model_use(vpn) : 1'b0;
    exp_q.push_back(xl ? {ppn_of(vpn), off} : {vpn, off});
    if (miss) exp_fill_vpn = vpn;
    f0 = fill_cnt;
    @(posedge clk); #1;
    req_valid = 1'b1; req_src = src; req_addr = {vpn, off};
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
    chk((fill_cnt - f0) == int'(miss), xl ? "R6/R7/R8 hit-miss per recency" : "R2 bypass raises no fill",
        fill_cnt - f0, int'(miss));
  endtask

  task automatic do_flush();
    @(posedge clk); #1 flush_i = 1'b1;
    @(posedge clk); #1 flush_i = 1'b0;
    lru_q.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!fill_req && !rsp_valid, "R1 reset outputs", {30'h0, fill_req, rsp_valid}, 0);
    // R2 R10 disabled PCI bypasses
    lookup(2'd2, 20'hABCDE, 12'h123);
    // R2 reserved source bypasses
    lookup(2'd3, 20'h00100, 12'h456);
    // R1 R3 R4 first host miss then hit via graphics master (R10 shared)
    lookup(2'd0, 20'h00100, 12'hFFF);
    lookup(2'd1, 20'h00100, 12'h001);
    // R6 fill the rest, then all hit
    for (int i = 1; i < 16; i++) lookup(2'd0, 20'h00100 + 20'(i), 12'(i));
    for (int i = 0; i < 16; i++) lookup(2'd1, 20'h00100 + 20'(i), 12'h800);
    // R7 R8 evictions under chosen order
    lookup(2'd0, 20'h00100, 12'h0);
    lookup(2'd0, 20'h00200, 12'h0);
    lookup(2'd0, 20'h00101, 12'h0);
    lookup(2'd0, 20'h00103, 12'h0);
    lookup(2'd0, 20'h00102, 12'h0);
    // R11 stray fill ignored
    @(posedge clk); #1 fill_valid = 1'b1; fill_ppn = 20'hDEAD0;
    @(posedge clk); #1 fill_valid = 1'b0;
    for (int i = 0; i < 16; i++) lookup(2'd0, lru_q[15 - i], 12'h5A5);
    // R5 switch stalled host miss to bypassed PCI request
    begin
      bit m;
      m = model_use(20'h00777);
      exp_fill_vpn = 20'h00777;
      @(posedge clk); #1;
      req_valid = 1'b1; req_src = 2'd0; req_addr = {20'h00777, 12'h010};
      do @(negedge clk); while (!fill_req);
      @(posedge clk); #1;
      exp_q.push_back({20'h55555, 12'h020});
      req_src = 2'd2; req_addr = {20'h55555, 12'h020};
      do @(negedge clk); while (!req_ready);
      @(posedge clk); #1 req_valid = 1'b0;
      chk(m == 1'b1, "R5 model miss", 0, 0);
    end
    lookup(2'd0, 20'h00777, 12'h011);
    // R9 flush
    do_flush();
    lookup(2'd1, 20'h00777, 12'h0);
    lookup(2'd1, 20'h00100, 12'h0);
    // R10 disable host only
    host_en = 1'b0;
    lookup(2'd0, 20'h00100, 12'h3);
    lookup(2'd1, 20'h00100, 12'h4);
    pci_en = 1'b1;
    lookup(2'd2, 20'h00100, 12'h5);
    // randomized phase
    for (int n = 0; n < 300; n++) begin
      if (n % 50 == 0) begin
        host_en = 1'($urandom);
        agp_en  = 1'($urandom);
        pci_en  = 1'($urandom);
      end
      if (n == 150) do_flush();
      lookup(2'($urandom), 20'h00300 + 20'($urandom % 24), 12'($urandom));
    end
    repeat (4) @(posedge clk);
    chk(exp_q.size() == 0, "R3 all responses seen", exp_q.size(), 0);
    finish_run();
  end
endmodule